// File: doc/BRIEF.md
# Packed Status Register with Masked Write

This block keeps a 32-bit processor status word. Four condition flags (negative, zero, carry and overflow) are held in their own flops, apart from the stored word. On every read they are ORed into the top four bit positions. The rest of the word sits in plain storage, and its lowest five bits form the mode field.

Software updates the word through one write port, which carries a value and a per-bit mask. If the mask touches any flag position, the write loads all four flags from the value, and the flag positions are then taken out of the mask before the storage merge. Once the merge is done, the flag positions in storage stay zero. If the write changes the stored mode field, the block raises a one-cycle request that carries the new mode. The banked-register logic next to it uses that request to swap its register sets.

An ALU can load the flags directly through a separate port. When both ports write the flags in the same cycle, the ALU port wins.

Top module: `ssr_status_reg`

## Requirements
- R1: After reset, `rd_value` is 0x00000000 and `mode_chg_valid` is low.
- R2: `rd_value` is combinational. It equals the stored word ORed with the flags at bit 31 (N), bit 30 (Z), bit 29 (C) and bit 28 (V). It shows every update made at the previous clock edge.
- R3: Take a software write with `wr_en` high and at least one bit of `wr_mask[31:28]` set, and with `alu_flag_we` low. It loads all four flags from `wr_value[31:28]`, even if only some of those mask bits are set.
- R4: Bits [31:28] of the stored word are never written and always read back as zero. Once the flags are cleared, `rd_value[31:28]` is zero even after a write whose value and mask are all ones.
- R5: On a write, stored bits [27:0] become (old & ~wr_mask) | (wr_value & wr_mask).
- R6: A write for which (old ^ wr_value) & wr_mask & 0x1F is nonzero makes `mode_chg_valid` high for the one cycle after the clock edge. In that cycle `mode_chg_mode` holds the new stored bits [4:0]. Any other cycle leaves `mode_chg_valid` low, including a write whose masked mode bits equal the stored ones.
- R7: When `alu_flag_we` is high, the flags take `alu_flags` (bit 3 = N, 2 = Z, 1 = C, 0 = V) at the clock edge, even if a software flag write happens in the same cycle.
- R8: While `wr_en` is low, `wr_value` and `wr_mask` have no effect on the stored word or on the mode request.
- R9: A write whose mask clears bits [4:0] leaves the mode field unchanged and raises no request, whatever the value's mode bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_value | input | 32 | Software write data |
| wr_mask | input | 32 | Per-bit write enable for the software write |
| alu_flag_we | input | 1 | ALU flag load strobe |
| alu_flags | input | 4 | ALU flags {N,Z,C,V} |
| rd_value | output | 32 | Packed status word |
| mode_chg_valid | output | 1 | One-cycle mode-switch request |
| mode_chg_mode | output | 5 | New mode carried with the request |

## Verification
The bench checks a partial flag mask (a single bit of [31:28]). A design that compared only some bits would load only some of the flags. It rewrites an unchanged mode under a full mode mask, and a design that tested the mask alone would raise a false request. It writes all ones to every bit, clears the flags, and reads back. A design that let flag bits into storage would show a nonzero top nibble. It also collides an ALU flag load with a software flag write, which shows a reversed priority as the wrong flags. Random traffic is then compared cycle by cycle against a behavioural model.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int WORD_W = 32;
  localparam int FLAG_W = 4;
  localparam int MODE_W = 5;
  localparam int BODY_W = WORD_W - FLAG_W;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
    logic ovf;
  } flags_t;

  localparam word_t FLAG_MASK = {{FLAG_W{1'b1}}, {BODY_W{1'b0}}};
  localparam word_t MODE_MASK = {{(WORD_W-MODE_W){1'b0}}, {MODE_W{1'b1}}};

  // Bitwise merge under a mask.
  function automatic word_t merge_bits(word_t old_w, word_t val_w, word_t msk_w);
    return (old_w & ~msk_w) | (val_w & msk_w);
  endfunction

  // True when a masked write alters the mode field.
  function automatic logic mode_delta(word_t old_w, word_t val_w, word_t msk_w);
    return |((old_w ^ val_w) & msk_w & MODE_MASK);
  endfunction

  // Read view: flags ORed over the stored word.
  function automatic word_t pack_read(flags_t f, word_t s);
    return {f, {BODY_W{1'b0}}} | s;
  endfunction
endpackage

// File: rtl/ssr_flag_bank.sv
module ssr_flag_bank
  import ssr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sw_we,
  input  flags_t sw_flags,
  input  logic   alu_we,
  input  flags_t alu_flags,
  output flags_t flags_q,
  output logic   flag_upd
);
  flags_t flags_d;

  always_comb begin
    flags_d = flags_q;
    if (alu_we)      flags_d = alu_flags;
    else if (sw_we)  flags_d = sw_flags;
  end

  assign flag_upd = alu_we | sw_we;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  // R7: ALU load wins
  a_r7_alu_priority: assert property (@(posedge clk) disable iff (!rst_n)
    alu_we |=> flags_q == $past(alu_flags));
  // R3: software flag load when ALU idle
  a_r3_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !alu_we) |=> flags_q == $past(sw_flags));
  // R2: flags hold without a load
  a_r2_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_upd |=> $stable(flags_q));
endmodule

// File: rtl/ssr_word_store.sv
module ssr_word_store
  import ssr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  word_t value,
  input  word_t mask,
  output word_t store_q,
  output logic  mode_hit,
  output logic [MODE_W-1:0] new_mode
);
  word_t eff_mask;
  word_t store_d;

  assign eff_mask = mask & ~FLAG_MASK;
  assign store_d  = merge_bits(store_q, value, eff_mask);
  assign mode_hit = we && mode_delta(store_q, value, eff_mask);
  assign new_mode = store_d[MODE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)  store_q <= '0;
    else if (we) store_q <= store_d;
  end

  // R8: idle port leaves storage alone
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(store_q));
  // R5: unmasked bits keep their value
  a_r5_masked_keep: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((store_q ^ $past(store_q)) & ~$past(mask)) == '0);
  // R4: flag positions never stored
  a_r4_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (store_q & FLAG_MASK) == '0);
endmodule

// File: rtl/ssr_mode_notify.sv
module ssr_mode_notify
  import ssr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [MODE_W-1:0] mode_in,
  output logic              valid_q,
  output logic [MODE_W-1:0] mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mode_q  <= '0;
    end else begin
      valid_q <= hit;
      if (hit) mode_q <= mode_in;
    end
  end

  // R6: request follows a detected change
  a_r6_pulse_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> valid_q && mode_q == $past(mode_in));
  // R6: no request without a change
  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !valid_q);
endmodule

// File: rtl/ssr_status_reg.sv
module ssr_status_reg
  import ssr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_value,
  input  logic [WORD_W-1:0] wr_mask,
  input  logic              alu_flag_we,
  input  logic [FLAG_W-1:0] alu_flags,
  output logic [WORD_W-1:0] rd_value,
  output logic              mode_chg_valid,
  output logic [MODE_W-1:0] mode_chg_mode
);
  logic   sw_flag_sel;
  flags_t flags_q;
  logic   flag_upd;
  word_t  store_q;
  logic   mode_hit;
  logic [MODE_W-1:0] new_mode;

  assign sw_flag_sel = wr_en && (|(wr_mask & FLAG_MASK));

  ssr_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n),
    .sw_we(sw_flag_sel), .sw_flags(flags_t'(wr_value[WORD_W-1 -: FLAG_W])),
    .alu_we(alu_flag_we), .alu_flags(flags_t'(alu_flags)),
    .flags_q(flags_q), .flag_upd(flag_upd)
  );

  ssr_word_store u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .value(wr_value), .mask(wr_mask),
    .store_q(store_q), .mode_hit(mode_hit), .new_mode(new_mode)
  );

  ssr_mode_notify u_notify (
    .clk(clk), .rst_n(rst_n), .hit(mode_hit), .mode_in(new_mode),
    .valid_q(mode_chg_valid), .mode_q(mode_chg_mode)
  );

  assign rd_value = pack_read(flags_q, store_q);

  // R6: request mode matches visible mode field
  a_r6_mode_visible: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg_valid |-> rd_value[MODE_W-1:0] == mode_chg_mode);
  // R2: top nibble of the read equals the flags
  a_r2_pack_top: assert property (@(posedge clk) disable iff (!rst_n)
    rd_value[WORD_W-1 -: FLAG_W] == flags_q);
endmodule

// File: tb/ssr_status_reg_tb_top.sv
`timescale 1ns/1ps
module ssr_status_reg_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0;
  logic [31:0] wr_value = 0, wr_mask = 0;
  logic alu_flag_we = 0;
  logic [3:0] alu_flags = 0;
  logic [31:0] rd_value;
  logic mode_chg_valid;
  logic [4:0] mode_chg_mode;

  int errors = 0, checks = 0;
  bit running = 0;

  // reference model state
  int unsigned m_flags = 0, m_store = 0, m_pmode = 0;
  bit m_pv = 0;

  always #5 clk = ~clk;

  ssr_status_reg dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural model, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_flags = 0; m_store = 0; m_pv = 0; m_pmode = 0;
    end else begin
      int unsigned msk, nxt;
      msk = wr_mask & 32'h0FFF_FFFF;
      m_pv = 0;
      if (wr_en) begin
        nxt = 0;
        for (int b = 0; b < 28; b++)
          nxt[b] = msk[b] ? wr_value[b] : m_store[b];
        if (nxt[4:0] != m_store[4:0]) begin
          m_pv = 1; m_pmode = nxt[4:0];
        end
        m_store = nxt;
      end
      if (alu_flag_we) m_flags = alu_flags;
      else if (wr_en && wr_mask[31:28] != 0) m_flags = wr_value[31:28];
    end
  end

  // continuous comparison away from the active edge
  always @(negedge clk) begin
    if (running) begin
      chk("R2 rd_value", rd_value, {m_flags[3:0], 28'h0} | m_store);
      chk("R6 mode_chg_valid", {31'h0, mode_chg_valid}, {31'h0, m_pv});
      if (m_pv) chk("R6 mode_chg_mode", {27'h0, mode_chg_mode}, {27'h0, m_pmode[4:0]});
    end
  end

  task automatic step(bit we, logic [31:0] v, logic [31:0] m, bit aw, logic [3:0] af);
    @(negedge clk);
    wr_en = we; wr_value = v; wr_mask = m; alu_flag_we = aw; alu_flags = af;
    @(negedge clk);
    wr_en = 0; alu_flag_we = 0;
  endtask

  initial begin
    #1_500_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset rd_value", rd_value, 32'h0);
    chk("R1 reset valid", {31'h0, mode_chg_valid}, 32'h0);
    running = 1;

    step(1, 32'hA000_0013, 32'hF000_001F, 0, 0);   // R3 R6
    chk("R3 flags loaded", rd_value, 32'hA000_0013);
    chk("R6 pulse", {31'h0, mode_chg_valid}, 32'h1);
    chk("R6 pulse mode", {27'h0, mode_chg_mode}, 32'h13);
    @(negedge clk);
    chk("R6 single cycle", {31'h0, mode_chg_valid}, 32'h0);

    step(1, 32'h0000_0013, 32'h0000_001F, 0, 0);   // same mode: R6
    chk("R6 no pulse same mode", {31'h0, mode_chg_valid}, 32'h0);
    chk("R6 word kept", rd_value, 32'hA000_0013);

    step(1, 32'h0000_1F05, 32'h0000_1F00, 0, 0);   // R9 R5
    chk("R9 mode untouched", rd_value, 32'hA000_1F13);
    chk("R9 no pulse", {31'h0, mode_chg_valid}, 32'h0);

    step(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);   // R8
    chk("R8 idle write ignored", rd_value, 32'hA000_1F13);
    chk("R8 no pulse", {31'h0, mode_chg_valid}, 32'h0);

    step(1, 32'h5FFF_FFF0, 32'hFFFF_FFFF, 0, 0);   // R5 R6
    chk("R5 full merge", rd_value, 32'h5FFF_FFF0);
    chk("R6 pulse mode 10", {27'h0, mode_chg_mode}, 32'h10);

    step(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 4'h0); // R4 R7
    chk("R4 top nibble clear", rd_value, 32'h0FFF_FFFF);

    step(1, 32'hF000_0000, 32'hF000_0000, 1, 4'h6); // R7
    chk("R7 alu wins", rd_value, 32'h6FFF_FFFF);

    step(1, 32'h9000_0000, 32'h1000_0000, 0, 0);   // R3 partial mask
    chk("R3 partial mask all flags", rd_value, 32'h9FFF_FFFF);

    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      wr_en = $urandom_range(0, 1);
      wr_value = $urandom;
      case ($urandom_range(0, 4))
        0: wr_mask = 32'hFFFF_FFFF;
        1: wr_mask = 32'h0000_001F;
        2: wr_mask = 32'h1 << $urandom_range(0, 31);
        3: wr_mask = 32'hF000_0000;
        default: wr_mask = $urandom;
      endcase
      alu_flag_we = ($urandom_range(0, 3) == 0);
      alu_flags = 4'($urandom);
    end
    @(negedge clk);
    wr_en = 0; alu_flag_we = 0;
    repeat (3) @(negedge clk);
    running = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule